// File: doc/BRIEF.md
# RAW10 Pixel Unpacker

This block takes the payload of a RAW10 image line as a stream of 32-bit words and turns it into a stream of 10-bit pixels, four pixels per output beat. On the wire, each set of four pixels takes five bytes. The first four bytes carry the upper eight bits of each pixel. The fifth byte gathers the two low bits of all four pixels. Bytes fill each input word starting from its least significant byte. A five-byte group therefore rarely lines up with a 32-bit word, so the block keeps the bytes left over from one word until the next word arrives.

Both sides use valid/ready handshakes. The line-end marker on the input word is passed on to the output beat that holds the last group of the line. A line whose payload is not a whole number of groups raises a one-cycle error flag. The bytes still held at that moment are dropped, so the next line starts cleanly aligned.

Top module: `raw10_depack`

## Requirements
- R1: After reset, `out_valid` and `line_err` are 0 and `in_ready` is 1.
- R2: For each five-byte group b0..b4, output pixel i (i = 0..3) is {b_i, b4[2i+1:2i]}, and it occupies `out_data[10i+9:10i]`.
- R3: Byte k of a line is taken from input word k/4, at bits [8(k%4)+7 : 8(k%4)]. Groups that straddle word boundaries are reassembled, so five input words produce exactly four output beats, in byte order.
- R4: While `out_valid` is 1 and `out_ready` is 0, the output beat holds: `out_valid`, `out_data` and `out_last` keep their values. In that state `in_ready` is 0.
- R5: For a line whose word count is a multiple of 5, `out_last` is 1 on the beat holding the final group and 0 on every other beat of the line.
- R6: For a line whose word count W is not a multiple of 5, `line_err` is 1 for exactly one cycle, the cycle after the final word is accepted, and `out_valid` is 0 in that cycle. The line yields floor(4(W-1)/5) beats, none with `out_last` set. Bytes still held when the final word arrives are discarded.
- R7: After any line end, good or bad, no byte is carried over: the next line's first group starts at its own byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_data | input | 32 | Packed payload bytes, first byte in bits 7:0 |
| in_last | input | 1 | Marks the final word of a line |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 40 | Four 10-bit pixels, pixel 0 in bits 9:0 |
| out_last | output | 1 | Beat holds the final group of a line |
| line_err | output | 1 | One-cycle pulse: line length was not a whole number of groups |

## Verification
The bench builds the block with its default parameters: 4-byte words, four pixels per group and two low bits per pixel. The leftover-byte pattern then repeats every five words, so a sweep of line lengths from 1 to 15 words passes through every residue of the word count modulo 5 three times. Each line length is run under three downstream readiness patterns (always ready, random, and mostly stalled), with input gaps added in the stalled case. This reaches every buffer fill level in the presence of both a simultaneous output take and input accept. A directed case holds `out_ready` low to freeze a beat and confirm that input stalls.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

   // How the word that carries the line-end marker leaves the buffer
   typedef enum logic [1:0] {
      END_NONE = 2'd0,
      END_GOOD = 2'd1,
      END_BAD  = 2'd2
   } line_end_e;

   // Bits needed to count 0..n
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rdp_byte_buf.sv
module rdp_byte_buf
   import rdp_pkg::*;
#(
   parameter int unsigned LANE_BYTES = 4,
   parameter int unsigned GRP_BYTES  = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [LANE_BYTES*8-1:0]  in_data,
   input  logic                     in_last,
   output logic                     grp_valid,
   input  logic                     grp_ready,
   output logic [GRP_BYTES*8-1:0]   grp_data,
   output logic                     grp_last,
   output logic                     bad_line
);

   localparam int unsigned BUF_BYTES = LANE_BYTES + GRP_BYTES - 1;
   localparam int unsigned BUF_W     = BUF_BYTES * 8;
   localparam int unsigned CW        = cnt_bits(BUF_BYTES);
   localparam int unsigned SW        = CW + 3;

   localparam logic [CW-1:0] GRP_C  = CW'(GRP_BYTES);
   localparam logic [CW-1:0] LANE_C = CW'(LANE_BYTES);

   logic [BUF_W-1:0] buf_q, buf_n, kept, merged;
   logic [CW-1:0]    cnt_q, cnt_n, rem;
   logic             last_q, last_n, err_n, err_q;
   logic             emit, take;
   line_end_e        end_kind;

   assign grp_valid = (cnt_q >= GRP_C);
   assign grp_data  = buf_q[GRP_BYTES*8-1:0];
   assign grp_last  = last_q;
   assign bad_line  = err_q;

   assign emit     = grp_valid & grp_ready;
   assign rem      = emit ? (cnt_q - GRP_C) : cnt_q;
   assign kept     = emit ? (buf_q >> (GRP_BYTES*8)) : buf_q;
   assign in_ready = (rem < GRP_C);
   assign take     = in_valid & in_ready;
   assign merged   = kept | (BUF_W'(in_data) << SW'({rem, 3'b000}));

   always_comb begin
      if (!(take && in_last))            end_kind = END_NONE;
      else if ((rem + LANE_C) == GRP_C)  end_kind = END_GOOD;
      else                               end_kind = END_BAD;
   end

   always_comb begin
      buf_n  = kept;
      cnt_n  = rem;
      last_n = last_q & ~emit;
      err_n  = 1'b0;
      unique case (end_kind)
         END_GOOD: begin
            buf_n  = merged;
            cnt_n  = GRP_C;
            last_n = 1'b1;
         end
         END_BAD: begin
            buf_n  = '0;
            cnt_n  = '0;
            last_n = 1'b0;
            err_n  = 1'b1;
         end
         default: begin
            if (take) begin
               buf_n = merged;
               cnt_n = rem + LANE_C;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         cnt_q  <= '0;
         last_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         buf_q  <= buf_n;
         cnt_q  <= cnt_n;
         last_q <= last_n;
         err_q  <= err_n;
      end
   end

endmodule

// File: rtl/rdp_grp_unpack.sv
module rdp_grp_unpack #(
   parameter int unsigned PIX_PER_GRP = 4,
   parameter int unsigned LSB_BITS    = 2
) (
   input  logic [(PIX_PER_GRP+1)*8-1:0]          grp_data,
   output logic [PIX_PER_GRP*(8+LSB_BITS)-1:0]   pix_data
);

   localparam int unsigned PIX_W   = 8 + LSB_BITS;
   localparam int unsigned LSB_OFS = PIX_PER_GRP * 8;

   for (genvar i = 0; i < PIX_PER_GRP; i++) begin : g_pix
      assign pix_data[i*PIX_W +: PIX_W] =
         {grp_data[i*8 +: 8], grp_data[LSB_OFS + i*LSB_BITS +: LSB_BITS]};
   end

endmodule

// File: rtl/raw10_depack.sv
module raw10_depack #(
   parameter int unsigned LANE_BYTES  = 4,
   parameter int unsigned PIX_PER_GRP = 4,
   parameter int unsigned LSB_BITS    = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   output logic                                  in_ready,
   input  logic [LANE_BYTES*8-1:0]               in_data,
   input  logic                                  in_last,
   output logic                                  out_valid,
   input  logic                                  out_ready,
   output logic [PIX_PER_GRP*(8+LSB_BITS)-1:0]   out_data,
   output logic                                  out_last,
   output logic                                  line_err
);

   localparam int unsigned GRP_BYTES = PIX_PER_GRP + 1;
   localparam int unsigned OUT_W     = PIX_PER_GRP * (8 + LSB_BITS);

   if (PIX_PER_GRP * LSB_BITS != 8) begin : g_bad_lsb
      $error("low bits of one group must fill exactly one byte");
   end
   if (LANE_BYTES >= GRP_BYTES) begin : g_bad_lane
      $error("input word must be narrower than one group");
   end

   logic [GRP_BYTES*8-1:0] grp_data;

   rdp_byte_buf #(
      .LANE_BYTES (LANE_BYTES),
      .GRP_BYTES  (GRP_BYTES)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_last   (in_last),
      .grp_valid (out_valid),
      .grp_ready (out_ready),
      .grp_data  (grp_data),
      .grp_last  (out_last),
      .bad_line  (line_err)
   );

   rdp_grp_unpack #(
      .PIX_PER_GRP (PIX_PER_GRP),
      .LSB_BITS    (LSB_BITS)
   ) u_unpack (
      .grp_data (grp_data),
      .pix_data (out_data)
   );

endmodule

// File: rtl/rdp_check.sv
module rdp_check #(
   parameter int unsigned OUT_W = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_last,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_data,
   input logic             out_last,
   input logic             line_err
);

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   a_r4_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   a_r5_line_end: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> ((out_valid && out_last) != line_err));

   a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      line_err |-> !out_valid);

   a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      line_err |=> !line_err);

endmodule

bind raw10_depack rdp_check #(.OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last),
   .line_err  (line_err)
);

// File: tb/sim_raw10_depack.sv
module sim_raw10_depack;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [39:0] out_data;
   logic        out_last;
   logic        line_err;

   always #10 clk = ~clk;

   raw10_depack u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_last   (in_last),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last),
      .line_err  (line_err)
   );

   int          checks = 0;
   int          fails = 0;
   int          err_seen = 0;
   int          mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [40:0] expq[$];
   logic [40:0] exp_beat;

   // downstream readiness pattern
   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
         0:       out_ready <= 1'b1;
         1:       out_ready <= lfsr[0];
         2:       out_ready <= lfsr[0] & lfsr[3];
         default: out_ready <= 1'b0;
      endcase
   end

   // output monitor, sampled 1 ns before the active edge
   always @(negedge clk) begin
      #9;
      if (rst_n) begin
         if (out_valid && out_ready) begin
            checks++;
            if (expq.size() == 0) begin
               fails++;
               $display("FAIL R3 surplus beat: actual last=%0b data=%h expected none",
                        out_last, out_data);
            end else begin
               exp_beat = expq.pop_front();
               if ({out_last, out_data} !== exp_beat) begin
                  fails++;
                  $display("FAIL R2 R5 beat: actual last=%0b data=%h expected last=%0b data=%h",
                           out_last, out_data, exp_beat[40], exp_beat[39:0]);
               end
            end
         end
         if (line_err) err_seen++;
      end
   end

   function automatic logic [7:0] bval(input int l, input int k);
      return 8'((k * 29 + l * 53 + 7) & 255);
   endfunction

   task automatic send_word(input logic [31:0] w, input logic lst);
      logic got;
      in_data  = w;
      in_last  = lst;
      in_valid = 1'b1;
      got = 1'b0;
      while (!got) begin
         #9;
         got = in_ready;
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic run_line(input int l, input int w, input bit gap);
      int nb;
      int ngrp;
      int e0;
      int waited;
      bit good;
      logic [39:0] d;
      logic [7:0]  lo;
      nb   = 4 * w;
      good = (w % 5 == 0);
      ngrp = good ? nb / 5 : (4 * (w - 1)) / 5;
      for (int g = 0; g < ngrp; g++) begin
         d  = '0;
         lo = bval(l, 5 * g + 4);
         for (int i = 0; i < 4; i++)
            d = d | (40'({bval(l, 5 * g + i), lo[2*i +: 2]}) << (10 * i));
         expq.push_back({(good && g == ngrp - 1), d});
      end
      e0 = err_seen;
      for (int k = 0; k < w; k++) begin
         send_word({bval(l, 4*k+3), bval(l, 4*k+2), bval(l, 4*k+1), bval(l, 4*k)},
                   (k == w - 1));
         if (gap && lfsr[2]) @(negedge clk);
      end
      waited = 0;
      while (expq.size() != 0 && waited < 400) begin
         @(negedge clk);
         waited++;
      end
      repeat (3) @(negedge clk);
      checks++;
      if (expq.size() != 0) begin
         fails++;
         $display("FAIL R3 R5 R7 line %0d (%0d words): actual %0d beats missing, expected 0",
                  l, w, expq.size());
         expq.delete();
      end
      checks++;
      if ((err_seen - e0) != (good ? 0 : 1)) begin
         fails++;
         $display("FAIL R6 line %0d (%0d words): actual %0d error pulses, expected %0d",
                  l, w, err_seen - e0, good ? 0 : 1);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL timeout: actual run still busy, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : main
      int l;
      logic [39:0] held;
      l = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #9;
      checks++;
      if (out_valid !== 1'b0 || line_err !== 1'b0 || in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R1 reset state: actual valid=%0b err=%0b ready=%0b expected 0 0 1",
                  out_valid, line_err, in_ready);
      end
      @(negedge clk);

      // sweep of line lengths under three readiness patterns (R2 R3 R5 R6 R7)
      for (int m = 0; m < 3; m++) begin
         mode = m;
         for (int w = 1; w <= 15; w++) begin
            run_line(l, w, (m == 2));
            l++;
         end
      end

      // R4: frozen output beat stalls the input
      mode = 3;
      repeat (2) @(negedge clk);
      fork
         run_line(l, 5, 1'b0);
      join_none
      repeat (12) @(negedge clk);
      #9;
      checks++;
      if (out_valid !== 1'b1 || in_ready !== 1'b0 || out_data !== expq[0][39:0]) begin
         fails++;
         $display("FAIL R4 stall: actual valid=%0b ready=%0b data=%h expected 1 0 %h",
                  out_valid, in_ready, out_data, expq[0][39:0]);
      end
      held = out_data;
      repeat (3) @(negedge clk);
      #9;
      checks++;
      if (out_valid !== 1'b1 || out_data !== held) begin
         fails++;
         $display("FAIL R4 hold: actual valid=%0b data=%h expected 1 %h",
                  out_valid, out_data, held);
      end
      @(negedge clk);
      mode = 0;
      wait fork;
      l++;

      // back-to-back bad then good line checks realignment (R7)
      run_line(l, 7, 1'b0);
      l++;
      run_line(l, 10, 1'b0);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule